// File: doc/BRIEF.md
# Serial Audio Receive Channel with Sample Queue

This block captures a two-slot serial audio stream and turns it into 16-bit samples. It watches three serial lines (bit clock, word select and data), all sampled in the system clock domain. Each rising edge of the bit clock captures one data bit. Word select marks which slot the bit belongs to. Once a slot has delivered sixteen bits, the assembled sample goes into a sixteen-entry queue, organised as two banks of eight words. A reader on the system side drains the queue through a valid/ready port. Each word read out carries a tag saying which slot it came from.

Three static controls choose how the stream is read. The first selects the framing: the standard format, where the first bit trails the word-select change by one bit clock, or left-justified, where the first bit arrives with the change. The second selects the bit order, most significant or least significant bit first. The third selects stereo or mono capture. Two sticky error flags feed a single interrupt line. One flag records samples lost to a full queue. The other records reads attempted on an empty queue. Each flag is cleared by a one-cycle clear pulse.

Top module: `audio_rx_chan`

## Requirements
- R1: While reset is held and just after it is released, rd_valid, rd_data, ovf_flag, udf_flag and irq are all 0.
- R2: A bit is taken from `i2s_sd` on each rising edge of `i2s_sck`. Word select low is the left slot and high is the right slot. A slot ends after sixteen bits. The slot that is in progress when reset is released is discarded.
- R3: With `cfg_lsb_first` = 0, the first bit of a slot becomes bit 15 of the sample and the last becomes bit 0.
- R4: With `cfg_lsb_first` = 1, the first bit of a slot becomes bit 0 of the sample and the last becomes bit 15.
- R5: With `cfg_left_just` = 0, the first bit of a slot is the one sampled one bit-clock edge after the edge where word select changed.
- R6: With `cfg_left_just` = 1, the first bit of a slot is the one sampled on the same bit-clock edge where word select changed.
- R7: With `cfg_mono` = 0, both slots are stored: left before right. `rd_right` is 0 for a left sample and 1 for a right sample.
- R8: With `cfg_mono` = 1, only left samples are stored and right-slot samples are discarded.
- R9: The queue holds 16 samples and returns them in arrival order. A word is removed on each clock where rd_valid and rd_ready are both 1.
- R10: A sample that completes while the queue holds 16 words is dropped. Dropping a sample sets `ovf_flag`, which stays set, and raises `irq`.
- R11: rd_data reads 0 while the queue is empty. Raising rd_ready while rd_valid is 0 sets `udf_flag`, which stays set, and raises `irq`.
- R12: A one-cycle pulse on `clr_ovf` or `clr_udf` clears the matching flag. `irq` is the OR of the two flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| i2s_sck | input | 1 | Serial bit clock |
| i2s_ws | input | 1 | Word select (0 left, 1 right) |
| i2s_sd | input | 1 | Serial data in |
| cfg_mono | input | 1 | 1: store left slot only |
| cfg_lsb_first | input | 1 | 1: least significant bit arrives first |
| cfg_left_just | input | 1 | 1: left-justified framing, 0: one-bit delayed framing |
| rd_valid | output | 1 | Queue holds at least one sample |
| rd_ready | input | 1 | Reader accepts the presented sample |
| rd_data | output | 16 | Oldest sample, 0 when the queue is empty |
| rd_right | output | 1 | Slot tag of rd_data |
| clr_ovf | input | 1 | Clear pulse for the overflow flag |
| clr_udf | input | 1 | Clear pulse for the underflow flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| udf_flag | output | 1 | Sticky underflow flag |
| irq | output | 1 | Interrupt, OR of both flags |

## Verification
The hardest condition to reach is the overflow. It needs the queue full of known data, followed by more complete slots in a correct frame. The stimulus gets there by streaming nine stereo frames without a break and without reading, which is eighteen samples against sixteen places. Once the stream stops, draining all sixteen words shows that the two late samples were dropped and that the order was kept. With the queue then empty, a single read attempt reaches the underflow, so both flags are set before the clear pulses are tried.

// File: rtl/audio_rx_pkg.sv
// Shared constants and the queue word layout for the audio receive channel.
package audio_rx_pkg;
    localparam int SAMPLE_W   = 16;
    localparam int BANK_WORDS = 8;
    localparam int BANKS      = 2;

    // One stored sample with its slot tag.
    typedef struct packed {
        logic                right;
        logic [SAMPLE_W-1:0] data;
    } rx_word_t;
endpackage

// File: rtl/rx_deser.sv
// Serial-to-parallel converter for one two-slot audio stream.
// Assumes: bit_tick is a one-cycle pulse per bit-clock rising edge, with
// ws_in and sd_in valid in that cycle. Framing and order are static.
module rx_deser
    import audio_rx_pkg::*;
#(
    parameter int W = SAMPLE_W
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     bit_tick,
    input  logic     ws_in,
    input  logic     sd_in,
    input  logic     cfg_lsb_first,
    input  logic     cfg_left_just,
    output logic     word_valid,
    output rx_word_t word
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic          ws_dly;
    logic          prev_eff;
    logic [1:0]    warm;
    logic          slot;
    logic [CW-1:0] cnt;
    logic [W-1:0]  shreg;
    logic          eff_ws;
    logic [W-1:0]  shifted;

    // Effective slot marker: delayed by one bit in the standard framing.
    always_comb eff_ws = cfg_left_just ? ws_in : ws_dly;

    // Next shift-register value for the configured bit order.
    always_comb shifted = cfg_lsb_first ? {sd_in, shreg[W-1:1]}
                                        : {shreg[W-2:0], sd_in};

    // Slot tracking, bit counting and sample assembly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws_dly     <= 1'b0;
            prev_eff   <= 1'b0;
            warm       <= 2'd0;
            slot       <= 1'b0;
            cnt        <= '0;
            shreg      <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            if (bit_tick) begin
                ws_dly   <= ws_in;
                prev_eff <= eff_ws;
                if (warm != 2'd2) warm <= warm + 2'd1;
                if (warm == 2'd2 && eff_ws != prev_eff) begin
                    slot  <= eff_ws;
                    shreg <= shifted;
                    cnt   <= CW'(1);
                end else if (cnt != '0 && cnt <= LAST) begin
                    shreg <= shifted;
                    cnt   <= cnt + CW'(1);
                    if (cnt == LAST) word_valid <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        word.right = slot;
        word.data  = shreg;
    end
endmodule

// File: rtl/rx_fifo.sv
// Ring-buffer queue for tagged samples.
// Assumes: the caller never writes when full; rd is only asserted when not empty.
// Read data is zero while empty.
module rx_fifo
    import audio_rx_pkg::*;
#(
    parameter int DEPTH = BANKS * BANK_WORDS
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr,
    input  rx_word_t wdata,
    input  logic     rd,
    output rx_word_t rdata,
    output logic     full,
    output logic     empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

    rx_word_t      mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] count;

    always_comb begin
        full  = (count == CW'(DEPTH));
        empty = (count == '0);
        rdata = empty ? '0 : mem[rp];
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (wr) mem[wp] <= wdata;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (wr) wp <= (wp == TOP) ? '0 : wp + AW'(1);
            if (rd) rp <= (rp == TOP) ? '0 : rp + AW'(1);
            if (wr && !rd)      count <= count + CW'(1);
            else if (rd && !wr) count <= count - CW'(1);
        end
    end

    // R9
    fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !rd) |=> (count == $past(count) + CW'(1)));
    // R9
    drain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !wr) |=> (count == $past(count) - CW'(1)));
endmodule

// File: rtl/audio_rx_chan.sv
// Receive channel top: input sampling, deserialiser, queue and error flags.
// Assumes: serial inputs are slow compared with clk (at least two clk per
// bit-clock phase); configuration is changed only around a reset.
module audio_rx_chan
    import audio_rx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                i2s_sck,
    input  logic                i2s_ws,
    input  logic                i2s_sd,
    input  logic                cfg_mono,
    input  logic                cfg_lsb_first,
    input  logic                cfg_left_just,
    output logic                rd_valid,
    input  logic                rd_ready,
    output logic [SAMPLE_W-1:0] rd_data,
    output logic                rd_right,
    input  logic                clr_ovf,
    input  logic                clr_udf,
    output logic                ovf_flag,
    output logic                udf_flag,
    output logic                irq
);
    logic     sck_q, sck_qq, ws_q, sd_q;
    logic     bit_tick;
    logic     word_valid;
    rx_word_t word, rword;
    logic     keep, fifo_wr, drop, pop, full, empty;

    // Register the serial lines and keep the previous bit-clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q  <= 1'b0;
            sck_qq <= 1'b0;
            ws_q   <= 1'b0;
            sd_q   <= 1'b0;
        end else begin
            sck_q  <= i2s_sck;
            sck_qq <= sck_q;
            ws_q   <= i2s_ws;
            sd_q   <= i2s_sd;
        end
    end

    always_comb bit_tick = sck_q && !sck_qq;

    rx_deser #(.W(SAMPLE_W)) u_deser (
        .clk           (clk),
        .rst_n         (rst_n),
        .bit_tick      (bit_tick),
        .ws_in         (ws_q),
        .sd_in         (sd_q),
        .cfg_lsb_first (cfg_lsb_first),
        .cfg_left_just (cfg_left_just),
        .word_valid    (word_valid),
        .word          (word)
    );

    // Store/drop decision for each finished sample, and the read handshake.
    always_comb begin
        keep     = word_valid && !(cfg_mono && word.right);
        fifo_wr  = keep && !full;
        drop     = keep && full;
        rd_valid = !empty;
        pop      = rd_valid && rd_ready;
        rd_data  = rword.data;
        rd_right = rword.right;
        irq      = ovf_flag || udf_flag;
    end

    rx_fifo #(.DEPTH(BANKS * BANK_WORDS)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (fifo_wr),
        .wdata (word),
        .rd    (pop),
        .rdata (rword),
        .full  (full),
        .empty (empty)
    );

    // Sticky error flags; setting wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
            udf_flag <= 1'b0;
        end else begin
            if (drop)         ovf_flag <= 1'b1;
            else if (clr_ovf) ovf_flag <= 1'b0;
            if (rd_ready && !rd_valid) udf_flag <= 1'b1;
            else if (clr_udf)          udf_flag <= 1'b0;
        end
    end

    // R10
    drop_sets_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> ovf_flag);
    // R11
    empty_read_sets_udf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ready && !rd_valid) |=> udf_flag);
    // R11
    empty_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0));
    // R12
    ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ovf && !drop) |=> !ovf_flag);
    // R8
    mono_left_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr && cfg_mono) |-> !word.right);
endmodule

// File: tb/sim_audio_rx_chan.sv
module sim_audio_rx_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        i2s_sck = 1'b0, i2s_ws = 1'b1, i2s_sd = 1'b0;
    logic        cfg_mono = 1'b0, cfg_lsb_first = 1'b0, cfg_left_just = 1'b0;
    logic        rd_valid, rd_ready = 1'b0, rd_right;
    logic [15:0] rd_data;
    logic        clr_ovf = 1'b0, clr_udf = 1'b0;
    logic        ovf_flag, udf_flag, irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    audio_rx_chan u0 (
        .clk(clk), .rst_n(rst_n), .i2s_sck(i2s_sck), .i2s_ws(i2s_ws), .i2s_sd(i2s_sd),
        .cfg_mono(cfg_mono), .cfg_lsb_first(cfg_lsb_first), .cfg_left_just(cfg_left_just),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .rd_right(rd_right),
        .clr_ovf(clr_ovf), .clr_udf(clr_udf), .ovf_flag(ovf_flag), .udf_flag(udf_flag),
        .irq(irq)
    );

    typedef struct packed {
        logic        mono;
        logic        lsb;
        logic        lj;
        logic [15:0] left_tx;
        logic [15:0] right_tx;
        logic [15:0] exp0;
        logic        tag0;
        logic [15:0] exp1;
        logic        tag1;
        logic [1:0]  nexp;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b0, 16'hA5C3, 16'h1234, 16'hA5C3, 1'b0, 16'h1234, 1'b1, 2'd2},
        '{1'b0, 1'b1, 1'b0, 16'h8001, 16'h7FFE, 16'h8001, 1'b0, 16'h7FFE, 1'b1, 2'd2},
        '{1'b0, 1'b0, 1'b1, 16'hF00F, 16'h0FF0, 16'hF00F, 1'b0, 16'h0FF0, 1'b1, 2'd2},
        '{1'b0, 1'b1, 1'b1, 16'h00FF, 16'hC35A, 16'h00FF, 1'b0, 16'hC35A, 1'b1, 2'd2},
        '{1'b1, 1'b0, 1'b0, 16'h5A5A, 16'hFFFF, 16'h5A5A, 1'b0, 16'h0000, 1'b0, 2'd1},
        '{1'b1, 1'b1, 1'b1, 16'h0001, 16'h8000, 16'h0001, 1'b0, 16'h0000, 1'b0, 2'd1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic tick(input logic w, input logic d);
        i2s_ws = w;
        i2s_sd = d;
        repeat (4) @(posedge clk);
        #1 i2s_sck = 1'b1;
        repeat (4) @(posedge clk);
        #1 i2s_sck = 1'b0;
    endtask

    task automatic send_slot(input logic [15:0] wd, input logic wsv, input logic next_ws,
                             input logic lsb, input logic lj);
        for (int i = 0; i < 16; i++) begin
            logic b, w;
            b = lsb ? wd[i] : wd[15-i];
            w = (!lj && i == 15) ? next_ws : wsv;
            tick(w, b);
        end
    endtask

    task automatic lead_in(input logic lj);
        tick(1'b1, 1'b0);
        tick(1'b1, 1'b0);
        tick(1'b1, 1'b0);
        tick(lj ? 1'b1 : 1'b0, 1'b0);
    endtask

    task automatic send_pair(input logic [15:0] l, input logic [15:0] r,
                             input logic lsb, input logic lj);
        send_slot(l, 1'b0, 1'b1, lsb, lj);
        send_slot(r, 1'b1, 1'b0, lsb, lj);
    endtask

    task automatic trailer();
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b0);
        repeat (6) @(posedge clk);
    endtask

    task automatic read_one(output logic [15:0] d, output logic r);
        int n = 0;
        @(negedge clk);
        while (!rd_valid && n < 100) begin
            @(negedge clk);
            n++;
        end
        d = rd_valid ? rd_data : 16'hDEAD;
        r = rd_right;
        if (rd_valid) begin
            rd_ready = 1'b1;
            @(posedge clk);
            #1 rd_ready = 1'b0;
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic        r;

        // R1: reset state
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 valid in reset", rd_valid, 0);
        check("R1 data in reset", rd_data, 0);
        check("R1 irq in reset", {ovf_flag, udf_flag, irq}, 0);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {rd_valid, ovf_flag, udf_flag, irq}, 0);

        // Table walk: R2 R3 R4 R5 R6 R7 R8
        for (int v = 0; v < NV; v++) begin
            cfg_mono      = VECS[v].mono;
            cfg_lsb_first = VECS[v].lsb;
            cfg_left_just = VECS[v].lj;
            do_reset();
            lead_in(VECS[v].lj);
            send_pair(VECS[v].left_tx, VECS[v].right_tx, VECS[v].lsb, VECS[v].lj);
            trailer();
            read_one(d, r);
            check("R2/R3/R4/R5/R6 first sample", {r, d}, {VECS[v].tag0, VECS[v].exp0});
            if (VECS[v].nexp == 2'd2) begin
                read_one(d, r);
                check("R7 right sample", {r, d}, {VECS[v].tag1, VECS[v].exp1});
            end
            @(negedge clk);
            check("R8 no extra sample", rd_valid, 0);
        end

        // R10 and R9: nine stereo frames against sixteen places
        cfg_mono = 1'b0; cfg_lsb_first = 1'b0; cfg_left_just = 1'b0;
        do_reset();
        lead_in(1'b0);
        for (int k = 0; k < 9; k++) send_pair(16'h1000 + 16'(k), 16'h2000 + 16'(k), 1'b0, 1'b0);
        trailer();
        @(negedge clk);
        check("R10 overflow flags", {ovf_flag, udf_flag, irq}, 3'b101);
        for (int k = 0; k < 8; k++) begin
            read_one(d, r);
            check("R9 order left", {r, d}, {1'b0, 16'h1000 + 16'(k)});
            read_one(d, r);
            check("R9 order right", {r, d}, {1'b1, 16'h2000 + 16'(k)});
        end
        @(negedge clk);
        check("R9 drained", {rd_valid, udf_flag}, 0);

        // R11: read on empty
        check("R11 empty data zero", rd_data, 0);
        rd_ready = 1'b1;
        @(posedge clk);
        #1 rd_ready = 1'b0;
        @(negedge clk);
        check("R11 underflow flag", {udf_flag, irq, rd_data}, {2'b11, 16'h0000});

        // R12: clear pulses
        clr_ovf = 1'b1;
        @(posedge clk);
        #1 clr_ovf = 1'b0;
        @(negedge clk);
        check("R12 ovf cleared", {ovf_flag, udf_flag, irq}, 3'b011);
        clr_udf = 1'b1;
        @(posedge clk);
        #1 clr_udf = 1'b0;
        @(negedge clk);
        check("R12 all cleared", {ovf_flag, udf_flag, irq}, 3'b000);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule